// File: doc/BRIEF.md
# Interleaved Block Reader

This block fetches a run of consecutive words from a set of memory modules in which neighbouring word addresses live in neighbouring modules. The module number is taken from the low address bits and the word's location inside that module from the high bits. A requester supplies a start address and a word count. The controller sends one address per cycle over a single shared address bus, one to each module the block touches. Each module then works through its own share of the block by itself. The controller drains the modules' data buffer registers one word per cycle, in ascending address order.

The modules are behavioural models with fixed latencies. Loading an address takes one cycle. The array access takes 6 cycles for a module's first word and 4 cycles for each later word. Moving a word out of the data buffer takes one cycle. Because the array accesses in different modules overlap, a block spread over four modules streams out far faster than it would from a single module. The number of modules is a power-of-two parameter.

Top module: `ilv_block_reader`

## Requirements
- R1: `req_ready` is high exactly while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high and `req_len` is non-zero. `req_ready` falls on the following cycle.
- R2: From acceptance through the cycle of `out_done`, `req_ready` stays low. Requests presented in that window are ignored and do not change the words delivered.
- R3: A request whose `req_len` is zero is ignored. No word is produced and `req_ready` stays high.
- R4: A request for L words produces exactly L `out_valid` cycles. They carry the addresses start, start+1, …, start+L-1 in that order, wrapping modulo 2^ADDR_W.
- R5: The word stored at address A (ADDR_W = 16, DATA_W = 32) is {A ^ 16'hA5C3, A}, with the XOR term in bits 31:16 and A in bits 15:0.
- R6: Word A lives in module A mod NUM_MODS. Addresses go out over the shared bus one module per cycle, in ascending word order, starting in cycle 1, the cycle after acceptance. No module receives an address and has its data buffer read in the same cycle.
- R7: Let n be NUM_MODS and use the default latencies. Word i of a block appears in cycle max(prev+1, (i mod n) + 8 + 4·⌊i/n⌋), where prev is the cycle of word i-1 (0 for word 0). This holds for n ≤ 4 and any start alignment.
- R8: An 8-word block finishes in cycle 15 with 4 modules, in cycle 21 with 2 modules and in cycle 36 with 1 module.
- R9: `out_done` is high in exactly the cycle that carries the last word of the block, and never without `out_valid`.
- R10: After reset, `req_ready` is 1 and `out_valid` and `out_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Block request strobe |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Number of words to read |
| req_ready | output | 1 | Idle, able to take a request |
| out_valid | output | 1 | A word is present on `out_data` |
| out_data | output | DATA_W | Word being delivered |
| out_done | output | 1 | Marks the last word of the block |

## Verification
The symptoms at the ports depend on which internal state is wrong.

- A module timer that runs long or short shifts the cycle of a delivered word, and this shows on the first word that module supplies, from cycle 8 onward.
- A wrong module selection or an out-of-order drain puts the wrong address's pattern on `out_data` at the very next valid cycle.
- A miscounted per-module share shows up in different ways. Either a word is missing, so the run stalls past its expected cycle, or an extra word leaves a data buffer full, which corrupts the next request's first delivery.
- A sequencer that leaves its busy state early or late shows as `req_ready` being wrong in the cycle after `out_done`.

Three widths of the block (1, 2 and 4 modules) run side by side on the same requests, so a timing fault that only appears with a particular module count is still caught.

// File: rtl/ilv_pkg.sv
// Shared types and the behavioural memory content used by the interleaved reader.
package ilv_pkg;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;
    typedef enum logic {BANK_IDLE, BANK_BUSY} bank_state_t;

    // Content held at a word address by the module models.
    function automatic logic [31:0] ilv_content(input logic [31:0] a);
        return {a[15:0] ^ 16'hA5C3, a[15:0]};
    endfunction

endpackage

// File: rtl/ilv_bank.sv
// Behavioural model of one memory module with an address buffer and a data buffer.
// Assumes it receives at most one address load per block. After the load it reads
// ld_cnt successive rows on its own. The first row takes T_FIRST cycles and each
// later row takes T_NEXT. A finished row waits in the array stage until the data
// buffer is empty or is being emptied in the same cycle.
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 6,
    parameter int K        = 2,
    parameter int BANK_ID  = 0,
    parameter int T_FIRST  = 6,
    parameter int T_NEXT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-K-1:0] ld_row,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic              take,
    output logic              dbr_full,
    output logic [DATA_W-1:0] dbr_data
);
    localparam int IW   = ADDR_W - K;
    localparam int TMAX = (T_FIRST > T_NEXT) ? T_FIRST : T_NEXT;
    localparam int TW   = $clog2(TMAX + 1);

    bank_state_t        st_q;
    logic [IW-1:0]      row_q;
    logic [CNT_W-1:0]   left_q;
    logic [TW-1:0]      tmr_q;
    logic [DATA_W-1:0]  dbr_q;
    logic               full_q;
    logic [ADDR_W-1:0]  gaddr;
    logic               arr_rdy;
    logic               deposit;

    // Global address of the row the array is currently reading.
    always_comb gaddr = (ADDR_W'(row_q) << K) | ADDR_W'(BANK_ID);
    // The array stage has finished a row, and the data buffer is free to accept it.
    always_comb begin
        arr_rdy = (st_q == BANK_BUSY) && (tmr_q == TW'(1));
        deposit = arr_rdy && (!full_q || take);
    end

    // Data buffer register: loaded when a row completes, emptied when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbr_q  <= '0;
            full_q <= 1'b0;
        end else if (deposit) begin
            dbr_q  <= DATA_W'(ilv_content(32'(gaddr)));
            full_q <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    // Array sequencing: latch the address, time each row, step to the next row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= BANK_IDLE;
            row_q  <= '0;
            left_q <= '0;
            tmr_q  <= '0;
        end else begin
            case (st_q)
                BANK_IDLE: if (ld) begin
                    row_q  <= ld_row;
                    left_q <= ld_cnt;
                    tmr_q  <= TW'(T_FIRST);
                    st_q   <= BANK_BUSY;
                end
                BANK_BUSY: begin
                    if (deposit) begin
                        if (left_q == CNT_W'(1)) begin
                            st_q <= BANK_IDLE;
                        end else begin
                            left_q <= left_q - CNT_W'(1);
                            row_q  <= row_q + IW'(1);
                            tmr_q  <= TW'(T_NEXT);
                        end
                    end else if (tmr_q > TW'(1)) begin
                        tmr_q <= tmr_q - TW'(1);
                    end
                end
                default: st_q <= BANK_IDLE;
            endcase
        end
    end

    assign dbr_full = full_q;
    assign dbr_data = dbr_q;

endmodule

// File: rtl/ilv_seq.sv
// Block sequencer. It accepts a request while idle and sends one address per cycle
// on the shared bus, in ascending word order, to each module the block touches.
// It then drains the data buffers in address order, one word per cycle.
// Assumes NUM_MODS is a power of two with K = log2(NUM_MODS).
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 6,
    parameter int NUM_MODS = 4,
    parameter int K        = 2,
    parameter int BW       = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [NUM_MODS-1:0]  full_vec,
    output logic                 req_ready,
    output logic [NUM_MODS-1:0]  ld_vec,
    output logic [ADDR_W-K-1:0]  ld_row,
    output logic [LEN_W-1:0]     ld_cnt,
    output logic [NUM_MODS-1:0]  take_vec,
    output logic [BW-1:0]        sel,
    output logic                 out_valid,
    output logic                 out_done
);
    localparam int IW = ADDR_W - K;

    seq_state_t         st_q;
    logic [ADDR_W-1:0]  base_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W:0]     slots_q;
    logic [LEN_W:0]     iss_q;
    logic [LEN_W-1:0]   out_q;
    logic [ADDR_W-1:0]  a_iss;
    logic [ADDR_W-1:0]  a_out;
    logic [LEN_W:0]     remain;
    logic [BW-1:0]      b_iss;
    logic               issuing;

    // Issue side: the next module on the bus, its row, and its share of the block.
    always_comb begin
        a_iss   = base_q + ADDR_W'(iss_q);
        b_iss   = BW'(a_iss % NUM_MODS);
        issuing = (st_q == SEQ_RUN) && (iss_q < slots_q);
        remain  = {1'b0, len_q} - (LEN_W+1)'(1) - iss_q;
        ld_row  = IW'(a_iss >> K);
        ld_cnt  = LEN_W'((remain >> K) + (LEN_W+1)'(1));
        ld_vec  = issuing ? (NUM_MODS'(1) << b_iss) : '0;
    end

    // Drain side: the module holding the next word in address order.
    always_comb begin
        a_out     = base_q + ADDR_W'(out_q);
        sel       = BW'(a_out % NUM_MODS);
        out_valid = (st_q == SEQ_RUN) && full_vec[sel];
        out_done  = out_valid && (out_q == len_q - LEN_W'(1));
        take_vec  = out_valid ? (NUM_MODS'(1) << sel) : '0;
        req_ready = (st_q == SEQ_IDLE);
    end

    // Request capture, issue counting and drain counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SEQ_IDLE;
            base_q  <= '0;
            len_q   <= '0;
            slots_q <= '0;
            iss_q   <= '0;
            out_q   <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: if (req_valid && (req_len != '0)) begin
                    base_q  <= req_addr;
                    len_q   <= req_len;
                    slots_q <= (32'(req_len) < NUM_MODS) ? {1'b0, req_len}
                                                          : (LEN_W+1)'(NUM_MODS);
                    iss_q   <= '0;
                    out_q   <= '0;
                    st_q    <= SEQ_RUN;
                end
                SEQ_RUN: begin
                    if (issuing)   iss_q <= iss_q + (LEN_W+1)'(1);
                    if (out_valid) out_q <= out_q + LEN_W'(1);
                    if (out_done)  st_q  <= SEQ_IDLE;
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ilv_block_reader.sv
// Top level: a sequencer plus NUM_MODS module models, interleaved on the low
// address bits. It streams a requested block out in address order.
module ilv_block_reader #(
    parameter int NUM_MODS = 4,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 6,
    parameter int T_FIRST  = 6,
    parameter int T_NEXT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_done
);
    localparam int K  = $clog2(NUM_MODS);
    localparam int BW = (K > 0) ? K : 1;
    localparam int IW = ADDR_W - K;

    logic [NUM_MODS-1:0] bank_ld;
    logic [NUM_MODS-1:0] bank_take;
    logic [NUM_MODS-1:0] bank_full;
    logic [DATA_W-1:0]   bank_dat [NUM_MODS];
    logic [IW-1:0]       bus_row;
    logic [LEN_W-1:0]    bus_cnt;
    logic [BW-1:0]       drain_sel;

    ilv_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_MODS(NUM_MODS), .K(K), .BW(BW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .full_vec(bank_full), .req_ready(req_ready),
        .ld_vec(bank_ld), .ld_row(bus_row), .ld_cnt(bus_cnt),
        .take_vec(bank_take), .sel(drain_sel),
        .out_valid(out_valid), .out_done(out_done)
    );

    for (genvar b = 0; b < NUM_MODS; b++) begin : g_bank
        ilv_bank #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(LEN_W), .K(K),
            .BANK_ID(b), .T_FIRST(T_FIRST), .T_NEXT(T_NEXT)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .ld(bank_ld[b]), .ld_row(bus_row), .ld_cnt(bus_cnt),
            .take(bank_take[b]),
            .dbr_full(bank_full[b]), .dbr_data(bank_dat[b])
        );
    end

    // Output word: the data buffer of the module currently being drained.
    always_comb out_data = bank_dat[drain_sel];

endmodule

// File: rtl/ilv_block_reader_chk.sv
// Protocol checker for ilv_block_reader, attached with bind.
module ilv_block_reader_chk #(
    parameter int NUM_MODS = 4,
    parameter int LEN_W    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [LEN_W-1:0]    req_len,
    input logic                req_ready,
    input logic                out_valid,
    input logic                out_done,
    input logic [NUM_MODS-1:0] ld_vec,
    input logic [NUM_MODS-1:0] take_vec
);
    assert_done_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_valid);

    assert_busy_while_streaming_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    assert_ready_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> req_ready);

    assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len != '0)) |=> !req_ready);

    assert_zero_len_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && (req_len == '0)) |=> req_ready);

    assert_one_addr_on_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_vec));

    assert_abr_dbr_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vec & take_vec) == '0);
endmodule

bind ilv_block_reader ilv_block_reader_chk #(.NUM_MODS(NUM_MODS), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .req_ready(req_ready), .out_valid(out_valid), .out_done(out_done),
    .ld_vec(bank_ld), .take_vec(bank_take)
);

// File: tb/sim_ilv_block_reader.sv
// Bench: three readers (4, 2 and 1 modules) driven by the same requests.
module sim_ilv_block_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [5:0]  req_len = '0;
    logic [2:0]  rdy, ov, od;
    logic [31:0] odat [3];
    int          vecs = 0;
    int          miss = 0;
    int          nm [3] = '{4, 2, 1};

    always #5 clk = ~clk;

    ilv_block_reader #(.NUM_MODS(4)) u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_addr(req_addr), .req_len(req_len), .req_ready(rdy[0]), .out_valid(ov[0]),
        .out_data(odat[0]), .out_done(od[0]));
    ilv_block_reader #(.NUM_MODS(2)) u1 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_addr(req_addr), .req_len(req_len), .req_ready(rdy[1]), .out_valid(ov[1]),
        .out_data(odat[1]), .out_done(od[1]));
    ilv_block_reader #(.NUM_MODS(1)) u2 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_addr(req_addr), .req_len(req_len), .req_ready(rdy[2]), .out_valid(ov[2]),
        .out_data(odat[2]), .out_done(od[2]));

    function automatic logic [31:0] word_at(input logic [15:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    // Earliest cycle of word i given the previous word's cycle (R7).
    function automatic int due(input int n, input int i, input int prev);
        int t = (i % n) + 8 + 4 * (i / n);
        return (t <= prev) ? prev + 1 : t;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vecs++;
        if (!ok) begin
            miss++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One block request; junk=1 keeps a conflicting request asserted while busy.
    task automatic run_req(input logic [15:0] a, input logic [5:0] l, input bit junk,
                           input int want_total);
        int  idx [3];
        int  nxt [3];
        int  fin [3];
        bit  alldone;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l;
        @(posedge clk);
        @(negedge clk);
        if (junk) begin
            req_addr = a ^ 16'h3C5A; req_len = 6'd3;
        end else begin
            req_valid = 1'b0;
        end
        for (int d = 0; d < 3; d++) begin
            idx[d] = 0; fin[d] = 0; nxt[d] = due(nm[d], 0, 0);
        end
        for (int cyc = 1; cyc < 400; cyc++) begin
            if (cyc > 1) @(negedge clk);
            alldone = 1'b1;
            for (int d = 0; d < 3; d++) begin
                if (fin[d] == 0) begin
                    if (cyc == 1) chk(rdy[d] == 1'b0, "R1", "ready after accept", rdy[d], 0);
                    if (ov[d]) begin
                        chk(cyc == nxt[d], "R7", "word cycle", cyc, nxt[d]);
                        chk(odat[d] == word_at(a + 16'(idx[d])), "R5 R4", "word data",
                            odat[d], word_at(a + 16'(idx[d])));
                        chk(od[d] == (idx[d] == int'(l) - 1), "R9", "done flag", od[d],
                            idx[d] == int'(l) - 1);
                        if (junk) chk(rdy[d] == 1'b0, "R2", "ready while busy", rdy[d], 0);
                        idx[d]++;
                        if (idx[d] == int'(l)) fin[d] = cyc;
                        else nxt[d] = due(nm[d], idx[d], nxt[d]);
                    end else if (cyc == nxt[d]) begin
                        chk(1'b0, "R7", "missing word", idx[d], nxt[d]);
                        fin[d] = cyc;
                    end
                end
                if (fin[d] == 0) alldone = 1'b0;
            end
            if (junk && (fin[0] != 0 || fin[1] != 0 || fin[2] != 0)) req_valid = 1'b0;
            if (alldone) break;
        end
        req_valid = 1'b0;
        for (int d = 0; d < 3; d++) begin
            chk(fin[d] != 0, "R4", "block completed", fin[d], 1);
            if (want_total != 0)
                chk(fin[d] == ((d == 0) ? 15 : (d == 1) ? 21 : 36), "R8", "total cycles",
                    fin[d], (d == 0) ? 15 : (d == 1) ? 21 : 36);
        end
        repeat (2) @(negedge clk);
        for (int d = 0; d < 3; d++) begin
            chk(rdy[d] == 1'b1, "R1", "ready when idle", rdy[d], 1);
            chk(ov[d] == 1'b0, "R2", "no stray word after block", ov[d], 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        logic [5:0] ln;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int d = 0; d < 3; d++) begin
            chk(rdy[d] == 1'b1, "R10", "reset ready", rdy[d], 1);
            chk(ov[d] == 1'b0 && od[d] == 1'b0, "R10", "reset outputs", {ov[d], od[d]}, 0);
        end
        run_req(16'h0000, 6'd8, 1'b0, 1);          // R8 aligned 8-word block
        run_req(16'h0123, 6'd1, 1'b0, 0);          // single word
        run_req(16'h0007, 6'd9, 1'b0, 0);          // unaligned start, R6 mapping
        run_req(16'hFFFD, 6'd6, 1'b0, 0);          // R4 address wrap
        run_req(16'h0040, 6'd12, 1'b1, 0);         // R2 request while busy
        // R3: zero length leaves the block idle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h5555; req_len = 6'd0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (12) begin
            @(negedge clk);
            for (int d = 0; d < 3; d++)
                chk(ov[d] == 1'b0 && rdy[d] == 1'b1, "R3", "zero length ignored",
                    {ov[d], rdy[d]}, 2'b01);
        end
        for (int n = 0; n < 25; n++) begin
            ln = 6'($urandom_range(1, 40));
            run_req(16'($urandom), ln, n[0], 0);
        end
        run_req(16'h0000, 6'd63, 1'b0, 0);         // longest block
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule